// File: doc/BRIEF.md
# Dual-Mode Accumulator Multiply-Accumulate Unit

This block is the arithmetic core behind a small signal-processing datapath. It holds a bank of four 40-bit accumulators. Each accumulator has a 32-bit body and 8 guard bits on top, so sums of many products can grow past 32 bits without wrapping. Each issued operation names a destination accumulator and a source accumulator, and may also use a 32-bit memory operand, a 16-bit coefficient and a shift count.

The operations are:
- a sign-extended 16-bit add;
- an add of a shifted second accumulator;
- a 16x16 multiply, signed or unsigned;
- a multiply-accumulate;
- a dual add that treats each accumulator as two independent lanes, a 24-bit upper lane and a 16-bit lower lane;
- a relational compare that sets or clears a single test flag.

Every write lands on the clock edge that samples the operation, so the new value can be read one cycle after issue. Each accumulator also has an overflow flag. The flag records whether the last add-type result written to that accumulator left the signed 40-bit range. Decode, operand fetch, saturation and rounding are done elsewhere.

Top module: `dual_mode_mac`

## Requirements
- R1: While `rst` is high at a rising edge, all accumulators, all overflow flags and the test flag become 0.
- R2: Operation code 1 (add short) sets dst = dst + sign-extended `mem_opnd[15:0]`, wrapped to 40 bits. The result is visible after the edge that samples the operation.
- R3: Operation code 2 (add shifted) sets dst = dst + (src arithmetically shifted left by `shift_amt`, 0 to 15), wrapped to 40 bits.
- R4: Operation code 3 (multiply) sets dst = src[15:0] * `coef`, sign-extended to 40 bits. Both factors are two's complement when `unsigned_mode` is 0 and unsigned when it is 1. The multiply clears the overflow flag of dst.
- R5: Operation code 4 (multiply-accumulate) sets dst = dst + the product defined in R4, wrapped to 40 bits.
- R6: Operation code 5 (dual add) sets dst[15:0] = (src[15:0] + `mem_opnd[15:0]`) mod 2^16. It sets dst[39:16] = (src[39:16] + `mem_opnd[31:16]` sign-extended to 24 bits) mod 2^24. No carry passes from bit 15 into bit 16, and the overflow flag of dst is cleared.
- R7: For operation codes 1, 2 and 4, the overflow flag of dst is set when the exact sum lies outside [-2^39, 2^39-1] and is cleared otherwise.
- R8: Operation code 6 (compare) sets the test flag to the truth of "dst REL src" on the following edge. The relation codes are 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal; codes 6 and 7 always yield 0. Values are compared as two's complement, or as unsigned when `unsigned_mode` is 1.
- R9: The following leave every accumulator and overflow flag unchanged: compare, code 0, code 7, and any cycle with `op_valid` low. Only a compare changes the test flag.
- R10: A writing operation changes no accumulator other than dst.
- R11: `acc_flat[40*i+39:40*i]` carries accumulator i. Within each field, bits 39:32 are the guard bits, bits 31:16 the high word and bits 15:0 the low word. `ovf_flags[i]` belongs to accumulator i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 3 | Operation select (see R2 to R9) |
| dst_sel | input | 2 | Destination / left-hand accumulator |
| src_sel | input | 2 | Source / right-hand accumulator |
| mem_opnd | input | 32 | Memory operand; low half for add short, both halves for dual add |
| coef | input | 16 | Coefficient factor for multiply and multiply-accumulate |
| shift_amt | input | 4 | Left shift of the source for add shifted |
| unsigned_mode | input | 1 | Unsigned multiply and compare |
| relation | input | 3 | Compare relation code |
| acc_flat | output | 160 | All accumulators, packed as in R11 |
| ovf_flags | output | 4 | Per-accumulator overflow flags |
| test_flag | output | 1 | Result of the last compare |

## Verification
Every result of this block is due exactly one rising edge after the operation is presented: accumulator values, overflow flags and the test flag alike. The bench presents each operation on a falling edge and lets one rising edge pass. It then compares all four accumulators, the overflow flags and the test flag against its arithmetic model on the next falling edge. Because the whole state is compared after every operation, effects on accumulators that should not change are caught in the same cycle as the intended write. The sweeps cover shift counts, signed and unsigned multiply corners, lane carries, and every relation against every pair of accumulators.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int ACC_W   = 40;
    localparam int GUARD_W = 8;
    localparam int BODY_W  = ACC_W - GUARD_W;
    localparam int LO_W    = 16;
    localparam int HI_W    = ACC_W - LO_W;
    localparam int OPD_W   = 16;
    localparam int MEM_W   = 2 * OPD_W;
    localparam int SH_W    = 4;
    localparam int PROD_W  = 2 * OPD_W + 2;
    localparam int WIDE_W  = ACC_W + (1 << SH_W) + 1;
    localparam int REL_W   = 3;
    localparam int OPC_W   = 3;

    typedef logic [ACC_W-1:0]         acc_t;
    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP   = 3'd0,
        OP_ADDK  = 3'd1,
        OP_ADDSH = 3'd2,
        OP_MPY   = 3'd3,
        OP_MAC   = 3'd4,
        OP_DUAL  = 3'd5,
        OP_CMP   = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [REL_W-1:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_LT = 3'd2,
        REL_LE = 3'd3,
        REL_GT = 3'd4,
        REL_GE = 3'd5,
        REL_X6 = 3'd6,
        REL_X7 = 3'd7
    } rel_e;

    typedef struct packed {
        logic wr;
        logic ovf;
        acc_t value;
    } wb_t;

    function automatic wide_t widen_acc(input acc_t v);
        return {{(WIDE_W-ACC_W){v[ACC_W-1]}}, v};
    endfunction

    function automatic wide_t widen_prod(input prod_t p);
        return {{(WIDE_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

    function automatic wide_t widen_opnd(input logic [OPD_W-1:0] v);
        return {{(WIDE_W-OPD_W){v[OPD_W-1]}}, v};
    endfunction

    function automatic logic fits_acc(input wide_t w);
        return w == widen_acc(w[ACC_W-1:0]);
    endfunction

endpackage

// File: rtl/dmac_mult.sv
module dmac_mult
    import dmac_pkg::*;
(
    input  logic [OPD_W-1:0] opnd_a,
    input  logic [OPD_W-1:0] opnd_b,
    input  logic             uns,
    output prod_t            product
);
    logic signed [OPD_W:0] a_ext;
    logic signed [OPD_W:0] b_ext;

    always_comb begin
        a_ext = {(uns ? 1'b0 : opnd_a[OPD_W-1]), opnd_a};
        b_ext = {(uns ? 1'b0 : opnd_b[OPD_W-1]), opnd_b};
        product = PROD_W'(a_ext * b_ext);
    end
endmodule

// File: rtl/dmac_cmp.sv
module dmac_cmp
    import dmac_pkg::*;
(
    input  acc_t lhs,
    input  acc_t rhs,
    input  logic uns,
    input  rel_e rel,
    output logic holds
);
    logic lt;
    logic eq;

    always_comb begin
        eq = (lhs == rhs);
        lt = uns ? (lhs < rhs) : ($signed(lhs) < $signed(rhs));
        case (rel)
            REL_EQ:  holds = eq;
            REL_NE:  holds = !eq;
            REL_LT:  holds = lt;
            REL_LE:  holds = lt || eq;
            REL_GT:  holds = !(lt || eq);
            REL_GE:  holds = !lt;
            default: holds = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmac_alu.sv
module dmac_alu
    import dmac_pkg::*;
(
    input  op_e              op,
    input  acc_t             dst_val,
    input  acc_t             src_val,
    input  logic [MEM_W-1:0] mem_opnd,
    input  prod_t            product,
    input  logic [SH_W-1:0]  shift_amt,
    output wb_t              wb
);
    wide_t           sum;
    logic [HI_W-1:0] hi_lane;
    logic [LO_W-1:0] lo_lane;

    always_comb begin
        sum     = '0;
        hi_lane = src_val[ACC_W-1:LO_W]
                + {{(HI_W-OPD_W){mem_opnd[MEM_W-1]}}, mem_opnd[MEM_W-1:OPD_W]};
        lo_lane = src_val[LO_W-1:0] + mem_opnd[LO_W-1:0];
        wb      = '0;
        case (op)
            OP_ADDK: begin
                sum      = widen_acc(dst_val) + widen_opnd(mem_opnd[OPD_W-1:0]);
                wb.wr    = 1'b1;
                wb.value = sum[ACC_W-1:0];
                wb.ovf   = !fits_acc(sum);
            end
            OP_ADDSH: begin
                sum      = widen_acc(dst_val) + (widen_acc(src_val) <<< shift_amt);
                wb.wr    = 1'b1;
                wb.value = sum[ACC_W-1:0];
                wb.ovf   = !fits_acc(sum);
            end
            OP_MPY: begin
                sum      = widen_prod(product);
                wb.wr    = 1'b1;
                wb.value = sum[ACC_W-1:0];
                wb.ovf   = 1'b0;
            end
            OP_MAC: begin
                sum      = widen_acc(dst_val) + widen_prod(product);
                wb.wr    = 1'b1;
                wb.value = sum[ACC_W-1:0];
                wb.ovf   = !fits_acc(sum);
            end
            OP_DUAL: begin
                wb.wr    = 1'b1;
                wb.value = {hi_lane, lo_lane};
                wb.ovf   = 1'b0;
            end
            default: wb = '0;
        endcase
    end
endmodule

// File: rtl/dual_mode_mac.sv
module dual_mode_mac
    import dmac_pkg::*;
#(
    parameter int N_ACC = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         op_valid,
    input  logic [OPC_W-1:0]             op_code,
    input  logic [$clog2(N_ACC)-1:0]     dst_sel,
    input  logic [$clog2(N_ACC)-1:0]     src_sel,
    input  logic [MEM_W-1:0]             mem_opnd,
    input  logic [OPD_W-1:0]             coef,
    input  logic [SH_W-1:0]              shift_amt,
    input  logic                         unsigned_mode,
    input  logic [REL_W-1:0]             relation,
    output logic [N_ACC*ACC_W-1:0]       acc_flat,
    output logic [N_ACC-1:0]             ovf_flags,
    output logic                         test_flag
);
    acc_t             acc_q [N_ACC];
    logic [N_ACC-1:0] ovf_q;
    logic             flag_q;
    acc_t             dst_val;
    acc_t             src_val;
    prod_t            prod;
    wb_t              wb;
    logic             cmp_hit;

    assign dst_val = acc_q[dst_sel];
    assign src_val = acc_q[src_sel];

    dmac_mult u_mult (
        .opnd_a  (src_val[OPD_W-1:0]),
        .opnd_b  (coef),
        .uns     (unsigned_mode),
        .product (prod)
    );

    dmac_alu u_alu (
        .op        (op_e'(op_code)),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .mem_opnd  (mem_opnd),
        .product   (prod),
        .shift_amt (shift_amt),
        .wb        (wb)
    );

    dmac_cmp u_cmp (
        .lhs   (dst_val),
        .rhs   (src_val),
        .uns   (unsigned_mode),
        .rel   (rel_e'(relation)),
        .holds (cmp_hit)
    );

    for (genvar i = 0; i < N_ACC; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[i] <= '0;
                ovf_q[i] <= 1'b0;
            end else if (op_valid && wb.wr && (int'(dst_sel) == i)) begin
                acc_q[i] <= wb.value;
                ovf_q[i] <= wb.ovf;
            end
        end

        assign acc_flat[i*ACC_W +: ACC_W] = acc_q[i];

        // R1
        a_r1_reset_clears: assert property (@(posedge clk)
            rst |=> (acc_q[i] == '0 && !ovf_q[i]));

        // R10
        a_r10_other_untouched: assert property (@(posedge clk) disable iff (rst)
            (op_valid && int'(dst_sel) != i) |=> ($stable(acc_q[i]) && $stable(ovf_q[i])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (op_valid && op_code == OP_CMP) begin
            flag_q <= cmp_hit;
        end
    end

    assign ovf_flags = ovf_q;
    assign test_flag = flag_q;

    // R9
    a_r9_flag_only_on_cmp: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op_code == OP_CMP) |=> $stable(flag_q));

    // R9
    a_r9_cmp_keeps_ovf: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CMP) |=> $stable(ovf_q));

    // R4
    a_r4_mpy_clears_ovf: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_MPY) |=> !ovf_q[$past(dst_sel)]);

    // R6
    a_r6_low_lane_wraps: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_DUAL) |=>
            acc_q[$past(dst_sel)][LO_W-1:0] == $past(LO_W'(mem_opnd[LO_W-1:0] + src_val[LO_W-1:0])));

    // R6
    a_r6_high_lane_no_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_DUAL) |=>
            acc_q[$past(dst_sel)][ACC_W-1:LO_W] == $past(HI_W'(src_val[ACC_W-1:LO_W]
                + {{(HI_W-OPD_W){mem_opnd[MEM_W-1]}}, mem_opnd[MEM_W-1:OPD_W]})));
endmodule

// File: tb/dual_mode_mac_bench.sv
`timescale 1ns/1ps
module dual_mode_mac_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [2:0]   op_code = '0;
    logic [1:0]   dst_sel = '0;
    logic [1:0]   src_sel = '0;
    logic [31:0]  mem_opnd = '0;
    logic [15:0]  coef = '0;
    logic [3:0]   shift_amt = '0;
    logic         unsigned_mode = 1'b0;
    logic [2:0]   relation = '0;
    logic [159:0] acc_flat;
    logic [3:0]   ovf_flags;
    logic         test_flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [39:0] m_acc [4];
    logic [3:0]  m_ovf;
    logic        m_flag;

    always #2.5 clk = ~clk;

    dual_mode_mac u_dual_mode_mac (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .dst_sel(dst_sel), .src_sel(src_sel), .mem_opnd(mem_opnd), .coef(coef),
        .shift_amt(shift_amt), .unsigned_mode(unsigned_mode), .relation(relation),
        .acc_flat(acc_flat), .ovf_flags(ovf_flags), .test_flag(test_flag)
    );

    function automatic logic signed [63:0] sx40(input logic [39:0] v);
        return {{24{v[39]}}, v};
    endfunction

    function automatic string req_of(input logic v, input logic [2:0] op);
        if (!v) return "R9";
        case (op)
            3'd1: return "R2 R7 R10 R11";
            3'd2: return "R3 R7 R10 R11";
            3'd3: return "R4 R10 R11";
            3'd4: return "R5 R7 R10 R11";
            3'd5: return "R6 R10 R11";
            3'd6: return "R8 R9";
            default: return "R9";
        endcase
    endfunction

    task automatic put(input int d, input logic signed [63:0] w);
        m_acc[d] = w[39:0];
        m_ovf[d] = (w != sx40(w[39:0]));
    endtask

    task automatic compare(input string tag);
        logic [159:0] exp_flat;
        exp_flat = {m_acc[3], m_acc[2], m_acc[1], m_acc[0]};
        checks++;
        if (acc_flat !== exp_flat || ovf_flags !== m_ovf || test_flag !== m_flag) begin
            fails++;
            $display("FAIL %s: acc=%h ovf=%b flag=%b expected acc=%h ovf=%b flag=%b",
                     tag, acc_flat, ovf_flags, test_flag, exp_flat, m_ovf, m_flag);
        end
    endtask

    task automatic issue(input logic v, input logic [2:0] op, input int d, input int s,
                         input logic [31:0] mem, input logic [15:0] cf,
                         input logic [3:0] sh, input logic u, input logic [2:0] rl);
        logic signed [63:0] w, a64, b64, p;
        logic lt, eq;
        op_valid = v; op_code = op; dst_sel = 2'(d); src_sel = 2'(s);
        mem_opnd = mem; coef = cf; shift_amt = sh; unsigned_mode = u; relation = rl;
        a64 = u ? {48'b0, m_acc[s][15:0]} : {{48{m_acc[s][15]}}, m_acc[s][15:0]};
        b64 = u ? {48'b0, cf} : {{48{cf[15]}}, cf};
        p = a64 * b64;
        @(posedge clk);
        if (v) begin
            case (op)
                3'd1: begin w = sx40(m_acc[d]) + {{48{mem[15]}}, mem[15:0]}; put(d, w); end
                3'd2: begin w = sx40(m_acc[d]) + (sx40(m_acc[s]) <<< sh); put(d, w); end
                3'd3: begin m_acc[d] = p[39:0]; m_ovf[d] = 1'b0; end
                3'd4: begin w = sx40(m_acc[d]) + p; put(d, w); end
                3'd5: begin
                    m_acc[d] = {24'(m_acc[s][39:16] + {{8{mem[31]}}, mem[31:16]}),
                                16'(m_acc[s][15:0] + mem[15:0])};
                    m_ovf[d] = 1'b0;
                end
                3'd6: begin
                    eq = (m_acc[d] == m_acc[s]);
                    lt = u ? (m_acc[d] < m_acc[s]) : (sx40(m_acc[d]) < sx40(m_acc[s]));
                    case (rl)
                        3'd0: m_flag = eq;
                        3'd1: m_flag = !eq;
                        3'd2: m_flag = lt;
                        3'd3: m_flag = lt || eq;
                        3'd4: m_flag = !(lt || eq);
                        3'd5: m_flag = !lt;
                        default: m_flag = 1'b0;
                    endcase
                end
                default: ;
            endcase
        end
        @(negedge clk);
        op_valid = 1'b0;
        compare(req_of(v, op));
    endtask

    task automatic set_acc(input int i, input logic [15:0] hi, input logic [15:0] lo);
        issue(1'b1, 3'd3, i, i, 32'h0, 16'h0, 4'd0, 1'b0, 3'd0);
        issue(1'b1, 3'd5, i, i, {hi, lo}, 16'h0, 4'd0, 1'b0, 3'd0);
    endtask

    initial begin
        logic [15:0] corners [5];
        corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'h7FFF;
        corners[3] = 16'h8000; corners[4] = 16'hFFFF;
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        m_ovf = '0; m_flag = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1");

        // R2: add short, every destination, sign corners
        for (int d = 0; d < 4; d++)
            for (int k = 0; k < 5; k++)
                issue(1'b1, 3'd1, d, 0, {16'hABCD, corners[k]}, 16'h0, 4'd0, 1'b0, 3'd0);

        // R3: every shift count
        set_acc(0, 16'h0000, 16'h1357);
        set_acc(3, 16'hFFFF, 16'hF00D);
        for (int sh = 0; sh < 16; sh++) begin
            issue(1'b1, 3'd2, 1, 0, 32'h0, 16'h0, 4'(sh), 1'b0, 3'd0);
            issue(1'b1, 3'd2, 2, 3, 32'h0, 16'h0, 4'(sh), 1'b0, 3'd0);
        end

        // R7: positive and negative overflow, then clearing by an in-range add
        set_acc(1, 16'h7FFF, 16'hFFFF);
        for (int n = 0; n < 3; n++) issue(1'b1, 3'd2, 1, 1, 32'h0, 16'h0, 4'd8, 1'b0, 3'd0);
        set_acc(2, 16'h8000, 16'h0000);
        for (int n = 0; n < 3; n++) issue(1'b1, 3'd2, 2, 2, 32'h0, 16'h0, 4'd9, 1'b0, 3'd0);
        set_acc(0, 16'h0000, 16'h0000);
        issue(1'b1, 3'd2, 0, 1, 32'h0, 16'h0, 4'd0, 1'b0, 3'd0);
        issue(1'b1, 3'd1, 0, 0, 32'h0000_0001, 16'h0, 4'd0, 1'b0, 3'd0);

        // R4 / R5: signed and unsigned multiply corners, accumulate into acc2
        set_acc(2, 16'h0000, 16'h0000);
        for (int u = 0; u < 2; u++)
            for (int a = 0; a < 5; a++)
                for (int c = 0; c < 5; c++) begin
                    set_acc(0, 16'h0000, corners[a]);
                    issue(1'b1, 3'd3, 1, 0, 32'h0, corners[c], 4'd0, 1'(u), 3'd0);
                    issue(1'b1, 3'd4, 2, 0, 32'h0, corners[c], 4'd0, 1'(u), 3'd0);
                end

        // R6: dual add lane carries stay inside each lane
        set_acc(3, 16'h0000, 16'hFFFF);
        issue(1'b1, 3'd5, 0, 3, 32'h0000_0001, 16'h0, 4'd0, 1'b0, 3'd0);
        set_acc(3, 16'hFFFF, 16'h8000);
        issue(1'b1, 3'd5, 1, 3, 32'h0001_8000, 16'h0, 4'd0, 1'b0, 3'd0);
        issue(1'b1, 3'd5, 3, 3, 32'h8000_7FFF, 16'h0, 4'd0, 1'b0, 3'd0);

        // R8: every relation, every accumulator pair, signed and unsigned
        set_acc(0, 16'h0000, 16'h0005);
        set_acc(1, 16'hFFFF, 16'hFFFF);
        set_acc(2, 16'h8000, 16'h0000);
        set_acc(3, 16'h0000, 16'h0005);
        for (int u = 0; u < 2; u++)
            for (int rl = 0; rl < 8; rl++)
                for (int d = 0; d < 4; d++)
                    for (int s = 0; s < 4; s++)
                        issue(1'b1, 3'd6, d, s, 32'h0, 16'h0, 4'd0, 1'(u), 3'(rl));

        // R9: idle, no-op, reserved code and invalid writes change nothing
        issue(1'b0, 3'd1, 0, 0, 32'h0000_7777, 16'h0, 4'd0, 1'b0, 3'd0);
        issue(1'b0, 3'd6, 0, 1, 32'h0, 16'h0, 4'd0, 1'b0, 3'd0);
        issue(1'b1, 3'd0, 2, 1, 32'hFFFF_FFFF, 16'hFFFF, 4'd5, 1'b0, 3'd0);
        issue(1'b1, 3'd7, 3, 2, 32'h1234_5678, 16'h4321, 4'd3, 1'b1, 3'd1);

        // R1: reset in mid-run clears everything again
        issue(1'b1, 3'd6, 0, 0, 32'h0, 16'h0, 4'd0, 1'b0, 3'd0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        m_ovf = '0; m_flag = 1'b0;
        compare("R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule